// File: doc/BRIEF.md
# Dual 8-bit Timer with Capture, Toggle Compare and PWM

The block holds two 8-bit up-counters. Each counter advances on a tick taken either from a shared free-running prescaler or from rising edges of an external event pin. Each counter returns to zero when it equals its limit and raises a one-cycle interrupt. A chain bit joins the two counters into one 16-bit counter with a 16-bit limit. The first counter's control byte also picks a mode. Interval mode only counts. Capture mode latches the count on a rising edge of a capture pin. Toggle mode flips the output pin on every match. PWM mode drives the output from a 10-bit count against a 10-bit period and a 10-bit duty value.

Software reaches the block through a simple register port. Writes take effect on the clock edge that samples them. Reads are combinational. In PWM mode the duty value is double-buffered: a write goes to a staging register, and that value is copied into the working register only when the period limit is reached. A duty change therefore always starts at the beginning of a period.

Top module: `tmr_pair`

## Requirements
- R1: With clock select 0,1,2,3,4,5,6 a counter advances once every 2,4,8,32,128,512,1024 system clocks. The select sits in control bits [2:0], at address 0 for counter A and address 1 for counter B.
- R2: Clock select 7 makes the counter advance once per rising edge of `evt_in`, after a two-flop synchronizer.
- R3: In interval mode (control A bits [6:5]=0) counter A counts 0..limit, where the limit is written at address 2. On the tick where count equals the limit it returns to 0 and pulses `irq0` for one cycle, so the `irq0` spacing is (limit+1) ticks.
- R4: Counter B has its own select (address 1), limit (address 3), run and clear bits, and pulses `irq1` with spacing (limit+1) ticks, independently of counter A.
- R5: Chain bit 7 of control A joins the counters into one 16-bit counter on counter A's tick, with limit {address 3, address 2}. Matches pulse `irq0`, and `irq1` stays low.
- R6: In capture mode (bits [6:5]=1) a rising edge of `cap_in` latches the count, and reads of addresses 2/3 return the latched low/high byte instead of the live count.
- R7: In toggle mode (bits [6:5]=2) `out_pin` starts low and flips on every counter A match, giving high and low phases of (limit+1) ticks each.
- R8: In PWM mode (bits [6:5]=3) the period is ({ext[3:2], address 4}+1) ticks and `out_pin` is high for the first ({ext[1:0], address 5}+1) ticks, where ext is address 6. A duty at or above the period keeps `out_pin` high. Each period start pulses `irq0`.
- R9: A duty write takes effect at the next period start: the period in which it is written keeps the old high time.
- R10: Run bit 3 cleared holds the counter at 0. Writing bit 4 as 1 zeroes the count on that write's edge, and bit 4 reads back as 0.
- R11: After reset every readable register returns 0, and `out_pin`, `irq0` and `irq1` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| evt_in | input | 1 | External event count input |
| cap_in | input | 1 | Capture trigger input |
| out_pin | output | 1 | Toggle or PWM output |
| irq0 | output | 1 | Counter A / chained / PWM period match pulse |
| irq1 | output | 1 | Counter B match pulse |

## Verification
The bench measures interrupt spacing at every prescaler ratio, at limit 0, at limit 255 and across a 16-bit chained limit. An off-by-one in the match compare would show up as one extra or one missing tick in that spacing. Event counting, clear, stop, and capture aliasing are checked by exact counts, so a capture that tracks the live count after the latch is caught. PWM is checked at a 10-bit period, at duty equal to and above the period, and with a duty write made mid-period. A design that loads duty at once instead of at the period start would change the high time of the current period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 10;
  localparam int PWM_W  = 10;

  localparam logic [2:0] SEL_EVENT = 3'd7;

  localparam logic [ADDR_W-1:0] A_CTRL0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT1  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PER   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DUTY  = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEXT  = 3'd6;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_CAPTURE  = 2'd1,
    MODE_TOGGLE   = 2'd2,
    MODE_PWM      = 2'd3
  } tmr_mode_e;

  // control byte: chain, mode, clear, run, clock select
  typedef struct packed {
    logic      chain;
    tmr_mode_e mode;
    logic      clr;
    logic      run;
    logic [2:0] sel;
  } ctrl_t;

  // log2 of the prescaler ratio for a clock select value
  function automatic int unsigned div_shift(input logic [2:0] sel);
    case (sel)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 7;
      3'd5:    return 9;
      default: return 10;
    endcase
  endfunction

  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
    logic [31:0] m;
    m = (32'd1 << div_shift(sel)) - 32'd1;
    return m[PRE_W-1:0];
  endfunction

  // output level inside a PWM period
  function automatic logic pwm_level(input logic [PWM_W-1:0] cnt,
                                     input logic [PWM_W-1:0] duty);
    return cnt <= duty;
  endfunction
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PW = PRE_W,
  parameter int NT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NT-1:0][2:0]   sel,
  input  logic                 evt_rise,
  output logic [NT-1:0]        tick
);
  logic [PW-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else        pre <= pre + PW'(1);
  end

  for (genvar g = 0; g < NT; g++) begin : g_tick
    logic [PW-1:0] msk;
    assign msk     = PW'(div_mask(sel[g]));
    assign tick[g] = (sel[g] == SEL_EVENT) ? evt_rise : ((pre & msk) == msk);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |=> (!tick[g] || !$stable(sel[g]))); // R1
  end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
  import tmr_pkg::*;
#(
  parameter int W = PWM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] duty_m,
  input  logic [W-1:0] cnt,
  output logic         level
);
  logic [W-1:0] duty_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_s <= '0;
    else if (load) duty_s <= duty_m;
  end

  assign level = en & pwm_level(PWM_W'(cnt), PWM_W'(duty_s));

  AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_s)); // R9
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int PW = PRE_W,
  parameter int MW = PWM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          evt_in,
  input  logic          cap_in,
  output logic          out_pin,
  output logic          irq0,
  output logic          irq1
);
  localparam int NT    = 2;
  localparam int CW    = 2 * DW;
  localparam int EXT_W = MW - DW;

  ctrl_t             c0, c1;
  logic [DW-1:0]     lim0, lim1, per_lo, duty_lo;
  logic [2*EXT_W-1:0] pext;
  logic [DW-1:0]     cnt0, cnt1;
  logic [CW-1:0]     cap_q;
  logic              cmp_q;

  // bus decode
  logic wr_c0, wr_c1, clr0, clr1;
  assign wr_c0 = wr_en && (wr_addr == A_CTRL0);
  assign wr_c1 = wr_en && (wr_addr == A_CTRL1);
  assign clr0  = wr_c0 && wr_data[4];
  assign clr1  = wr_c1 && wr_data[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0 <= '0; c1 <= '0; lim0 <= '0; lim1 <= '0;
      per_lo <= '0; duty_lo <= '0; pext <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL0: c0      <= ctrl_t'({wr_data[7:5], 1'b0, wr_data[3:0]});
        A_CTRL1: c1      <= ctrl_t'({wr_data[7:5], 1'b0, wr_data[3:0]});
        A_CNT0:  lim0    <= wr_data;
        A_CNT1:  lim1    <= wr_data;
        A_PER:   per_lo  <= wr_data;
        A_DUTY:  duty_lo <= wr_data;
        A_PEXT:  pext    <= wr_data[2*EXT_W-1:0];
        default: ;
      endcase
    end
  end

  // mode decode
  logic pwm_on, tgl_on, cap_on, joined;
  assign pwm_on = (c0.mode == MODE_PWM);
  assign tgl_on = (c0.mode == MODE_TOGGLE);
  assign cap_on = (c0.mode == MODE_CAPTURE);
  assign joined = c0.chain || pwm_on;

  // tick sources
  logic evt_rise, cap_rise;
  logic [NT-1:0]      tick;
  logic [NT-1:0][2:0] sel_v;
  assign sel_v = {c1.sel, c0.sel};

  tmr_sync_edge #(.STAGES(2)) u_evt (.clk(clk), .rst_n(rst_n), .d(evt_in), .rise(evt_rise));
  tmr_sync_edge #(.STAGES(2)) u_cap (.clk(clk), .rst_n(rst_n), .d(cap_in), .rise(cap_rise));

  tmr_prescale #(.PW(PW), .NT(NT)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(sel_v), .evt_rise(evt_rise), .tick(tick)
  );

  // step and match events, brought out for checking
  logic run_a, run_b, step_a, step_b, hit_a, hit_b;
  logic [CW-1:0] cnt16, lim16, per16;
  logic [MW-1:0] duty_m;
  assign cnt16  = {cnt1, cnt0};
  assign lim16  = {lim1, lim0};
  assign per16  = CW'({pext[2*EXT_W-1:EXT_W], per_lo});
  assign duty_m = {pext[EXT_W-1:0], duty_lo};

  assign run_a  = c0.run && !clr0;
  assign run_b  = joined ? run_a : (c1.run && !clr1);
  assign step_a = run_a && tick[0];
  assign step_b = joined ? step_a : (run_b && tick[1]);
  assign hit_a  = step_a && (pwm_on   ? (cnt16 >= per16) :
                             c0.chain ? (cnt16 == lim16) : (cnt0 == lim0));
  assign hit_b  = !joined && step_b && (cnt1 == lim1);

  // counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt0 <= '0;
      cnt1 <= '0;
    end else if (joined) begin
      if (!run_a || hit_a) {cnt1, cnt0} <= '0;
      else if (step_a)     {cnt1, cnt0} <= cnt16 + CW'(1);
    end else begin
      if (!run_a || hit_a) cnt0 <= '0;
      else if (step_a)     cnt0 <= cnt0 + DW'(1);
      if (!run_b || hit_b) cnt1 <= '0;
      else if (step_b)     cnt1 <= cnt1 + DW'(1);
    end
  end

  // interrupts, capture and toggle output
  logic cap_take;
  assign cap_take = cap_on && cap_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq0  <= 1'b0;
      irq1  <= 1'b0;
      cap_q <= '0;
      cmp_q <= 1'b0;
    end else begin
      irq0 <= hit_a;
      irq1 <= hit_b;
      if (cap_take) cap_q <= cnt16;
      if (!tgl_on)    cmp_q <= 1'b0;
      else if (hit_a) cmp_q <= ~cmp_q;
    end
  end

  logic pwm_lvl;
  tmr_pwm #(.W(MW)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en(pwm_on), .load(hit_a && pwm_on),
    .duty_m(duty_m), .cnt(cnt16[MW-1:0]), .level(pwm_lvl)
  );

  assign out_pin = pwm_on ? pwm_lvl : cmp_q;

  // read port
  always_comb begin
    case (rd_addr)
      A_CTRL0: rd_data = c0;
      A_CTRL1: rd_data = c1;
      A_CNT0:  rd_data = cap_on ? cap_q[DW-1:0]  : cnt0;
      A_CNT1:  rd_data = cap_on ? cap_q[CW-1:DW] : cnt1;
      A_PER:   rd_data = per_lo;
      A_DUTY:  rd_data = duty_lo;
      A_PEXT:  rd_data = DW'(pext);
      default: rd_data = '0;
    endcase
  end

  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !c0.run |=> (cnt0 == '0)); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr0 |=> (cnt0 == '0)); // R10
  AST_MATCH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> (cnt0 == '0 && irq0)); // R3
  AST_B_QUIET_CHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    joined |=> !irq1); // R5
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (tgl_on && hit_a) |=> (cmp_q != $past(cmp_q))); // R7
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_take |=> $stable(cap_q)); // R6
endmodule

// File: tb/tmr_pair_test.sv
module tmr_pair_test;
  import tmr_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       evt_in = 1'b0;
  logic       cap_in = 1'b0;
  logic       out_pin, irq0, irq1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tmr_pair uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in), .cap_in(cap_in),
    .out_pin(out_pin), .irq0(irq0), .irq1(irq1)
  );

  // kind: 0 counter A, 1 counter B, 2 chained
  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  sel;
    logic [15:0] lim;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 16'd5},   '{2'd0, 3'd1, 16'd3},   '{2'd0, 3'd2, 16'd0},
    '{2'd0, 3'd3, 16'd2},   '{2'd0, 3'd4, 16'd1},   '{2'd0, 3'd5, 16'd0},
    '{2'd0, 3'd6, 16'd0},   '{2'd1, 3'd0, 16'd7},   '{2'd1, 3'd2, 16'd4},
    '{2'd2, 3'd0, 16'h0102}, '{2'd0, 3'd0, 16'd255}
  };

  function automatic int ratio(input logic [2:0] s);
    case (s)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 32;
      3'd4: return 128;
      3'd5: return 512;
      default: return 1024;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic pulse_evt();
    @(negedge clk); evt_in = 1'b1;
    repeat (2) @(negedge clk);
    evt_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_in = 1'b1;
    repeat (2) @(negedge clk);
    cap_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_irq(input int which);
    int guard = 0;
    while (!(which == 1 ? irq1 : irq0) && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // cycles from one period start (inclusive) to the next
  task automatic pwm_measure(output int hi, output int len);
    wait_irq(0);
    hi = 0; len = 0;
    do begin
      if (out_pin) hi++;
      len++;
      @(negedge clk);
    end while (!irq0 && len < 5000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, hi, lo, len, t0, w, expv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      chk("R11", v, 0, $sformatf("reset read addr %0d", a));
    end
    chk("R11", int'(out_pin), 0, "reset out_pin");
    chk("R11", int'(irq0), 0, "reset irq0");
    chk("R11", int'(irq1), 0, "reset irq1");

    // R1 R3 R4 R5: interrupt spacing from the vector table
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL0, 8'h00);
      wr(A_CTRL1, 8'h00);
      w = (VECS[i].kind == 2'd1) ? 1 : 0;
      case (VECS[i].kind)
        2'd0: begin
          wr(A_CNT0, VECS[i].lim[7:0]);
          wr(A_CTRL0, 8'h18 | {5'd0, VECS[i].sel});
        end
        2'd1: begin
          wr(A_CNT1, VECS[i].lim[7:0]);
          wr(A_CTRL1, 8'h18 | {5'd0, VECS[i].sel});
        end
        default: begin
          wr(A_CNT0, VECS[i].lim[7:0]);
          wr(A_CNT1, VECS[i].lim[15:8]);
          wr(A_CTRL0, 8'h98 | {5'd0, VECS[i].sel});
        end
      endcase
      wait_irq(w);
      t0 = cyc;
      @(negedge clk);
      wait_irq(w);
      expv = (int'(VECS[i].lim) + 1) * ratio(VECS[i].sel);
      chk(VECS[i].kind == 2'd1 ? "R4" : (VECS[i].kind == 2'd2 ? "R5" : "R1_R3"),
          cyc - t0, expv, $sformatf("irq spacing vector %0d", i));
      if (VECS[i].kind == 2'd2) chk("R5", int'(irq1), 0, "irq1 low while chained");
    end
    wr(A_CTRL1, 8'h00);

    // R2 event counting
    wr(A_CTRL0, 8'h00);
    wr(A_CNT0, 8'hFF);
    wr(A_CTRL0, 8'h1F);
    repeat (4) pulse_evt();
    rd(A_CNT0, v);
    chk("R2", v, 4, "count after 4 events");

    // R10 clear bit, then further counting
    wr(A_CTRL0, 8'h1F);
    rd(A_CNT0, v);
    chk("R10", v, 0, "count after clear");
    rd(A_CTRL0, v);
    chk("R10", v, 8'h0F, "clear bit reads back 0");
    repeat (2) pulse_evt();
    rd(A_CNT0, v);
    chk("R2", v, 2, "count after clear and 2 events");

    // R10 run bit low holds zero
    wr(A_CTRL0, 8'h07);
    repeat (3) pulse_evt();
    rd(A_CNT0, v);
    chk("R10", v, 0, "stopped counter stays 0");

    // R3 wrap on limit with event ticks
    wr(A_CNT0, 8'd2);
    wr(A_CTRL0, 8'h1F);
    repeat (2) pulse_evt();
    rd(A_CNT0, v);
    chk("R3", v, 2, "count at limit");
    pulse_evt();
    rd(A_CNT0, v);
    chk("R3", v, 0, "count wrapped after limit");

    // R6 capture
    wr(A_CNT0, 8'hFF);
    wr(A_CTRL0, 8'h3F);
    repeat (5) pulse_evt();
    pulse_cap();
    rd(A_CNT0, v);
    chk("R6", v, 5, "captured count");
    repeat (3) pulse_evt();
    rd(A_CNT0, v);
    chk("R6", v, 5, "capture held while counting");
    rd(A_CNT1, v);
    chk("R6", v, 0, "captured high byte");
    wr(A_CTRL0, 8'h0F);
    rd(A_CNT0, v);
    chk("R6", v, 8, "live count outside capture mode");

    // R7 toggle output
    wr(A_CTRL0, 8'h00);
    wr(A_CNT0, 8'd3);
    wr(A_CTRL0, 8'h58);
    hi = 0; lo = 0; len = 0;
    while (!out_pin && len < 5000) begin @(negedge clk); len++; end
    while (out_pin && hi < 5000) begin hi++; @(negedge clk); end
    while (!out_pin && lo < 5000) begin lo++; @(negedge clk); end
    chk("R7", hi, 8, "toggle high phase");
    chk("R7", lo, 8, "toggle low phase");

    // R8 PWM basic
    wr(A_CTRL0, 8'h00);
    wr(A_PER, 8'd9);
    wr(A_PEXT, 8'h00);
    wr(A_DUTY, 8'd3);
    wr(A_CTRL0, 8'h78);
    pwm_measure(hi, len);
    pwm_measure(hi, len);
    chk("R8", len, 20, "pwm period");
    chk("R8", hi, 8, "pwm high time");

    // R9 duty write mid-period
    pwm_measure(hi, len);
    wait_irq(0);
    hi = 0; len = 0;
    do begin
      if (out_pin) hi++;
      len++;
      if (len == 3) begin wr_en = 1'b1; wr_addr = A_DUTY; wr_data = 8'd7; end
      if (len == 4) wr_en = 1'b0;
      @(negedge clk);
    end while (!irq0 && len < 5000);
    chk("R9", hi, 8, "old duty kept in write period");
    pwm_measure(hi, len);
    chk("R9", hi, 16, "new duty from next period");

    // R8 10-bit period
    wr(A_PER, 8'd0);
    wr(A_PEXT, 8'h04);
    wr(A_DUTY, 8'd5);
    pwm_measure(hi, len);
    pwm_measure(hi, len);
    chk("R8", len, 514, "10-bit pwm period");
    chk("R8", hi, 12, "10-bit pwm high time");

    // R8 duty equal to and above period
    wr(A_PER, 8'd9);
    wr(A_PEXT, 8'h00);
    wr(A_DUTY, 8'd9);
    pwm_measure(hi, len);
    pwm_measure(hi, len);
    chk("R8", hi, 20, "duty equal period stays high");
    wr(A_PEXT, 8'h01);
    wr(A_DUTY, 8'd0);
    pwm_measure(hi, len);
    pwm_measure(hi, len);
    chk("R8", hi, len, "duty above period stays high");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule